// File: doc/BRIEF.md
# Falling-grid state update engine

This block holds the playfield of a falling-block game: a grid of rows, each a few bits wide, kept in a small single-port RAM. The engine applies two kinds of whole-grid moves. A horizontal move rotates every row circularly by one bit, to the left or to the right. A gravity move shifts the whole grid down by one row and clears the top row. Each move is a short sequenced walk over the RAM. It starts on a one-cycle pulse, raises a busy flag while it runs, and ends with a one-cycle done pulse.

Only one RAM access happens per clock. The read of a row and its write-back therefore take separate cycles. The gravity walk runs from the highest row down, so no row is overwritten before it has been copied. While the engine is idle, the RAM is available on a host port. The rest of the game uses this port to place new pieces, and the frame encoder uses it to fetch rows for display.

Top module: `grid_engine`

## Requirements
- R1: While idle, a host write with `host_we` high stores `host_wdata` at row `host_addr`. A host read returns the row addressed by `host_addr` on `rd_data` one clock after the address is sampled.
- R2: A `start_shift` pulse with `move_left`=1 and `move_right`=0 rotates every row left by one: bit i moves to bit i+1, and the most significant bit moves to bit 0.
- R3: A `start_shift` pulse with `move_right`=1 and `move_left`=0 rotates every row right by one: bit i+1 moves to bit i, and bit 0 moves to the most significant bit.
- R4: A `start_shift` pulse with both direction inputs high, or both low, leaves every row unchanged, but the walk still runs and still pulses `done`.
- R5: A `start_fall` pulse sets row i to the old row i-1 for every i from ROWS-1 down to 1, and sets row 0 to all zeros.
- R6: `busy` rises in the cycle after an accepted start. It stays high for 2*ROWS cycles on a horizontal move and for 2*ROWS-1 cycles on a gravity move. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R7: While `busy` is high, start pulses and host writes are ignored and leave the grid unchanged.
- R8: If `start_shift` and `start_fall` arrive in the same idle cycle, only the horizontal move runs, and no gravity move follows it.
- R9: After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_shift | input | 1 | One-cycle pulse that starts a horizontal move |
| move_left | input | 1 | Direction request for the horizontal move |
| move_right | input | 1 | Direction request for the horizontal move |
| start_fall | input | 1 | One-cycle pulse that starts a gravity move |
| host_addr | input | $clog2(ROWS) | Row address for host access while idle |
| host_we | input | 1 | Host write enable, honoured only while idle |
| host_wdata | input | WIDTH | Row value for a host write |
| rd_data | output | WIDTH | Row read through the host port, one cycle latency |
| busy | output | 1 | High while a move is in progress |
| done | output | 1 | One-cycle pulse when a move completes |

## Verification
Two cases are hard to reach from the ports: a start pulse or a host write that lands in the middle of a walk, and two start pulses that arrive in the same idle cycle. The bench loads a distinct value into every row. It then drives a gravity pulse, a second horizontal pulse and a host write to a row that has already been processed, all a few cycles into a running move. A full readback must match a model in which only the first move happened. It also fires both starts together and checks that `busy` stays low after the single `done`.

// File: rtl/grid_pkg.sv
package grid_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_CLEAR
    } walk_state_t;

    typedef enum logic {
        OP_ROT,
        OP_FALL
    } walk_op_t;

    typedef enum logic [1:0] {
        DIR_HOLD,
        DIR_LEFT,
        DIR_RIGHT
    } rot_dir_t;

    typedef enum logic [1:0] {
        WS_ROT,
        WS_COPY,
        WS_ZERO
    } wsrc_t;
endpackage

// File: rtl/grid_ram.sv
module grid_ram #(
    parameter int ROWS  = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic [AW-1:0]    addr,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata_q
);
    logic [WIDTH-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else begin
            rdata_q <= mem[addr];
        end
    end
endmodule

// File: rtl/row_rotate.sv
module row_rotate
    import grid_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] din,
    input  rot_dir_t         dir,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] to_left;
    logic [WIDTH-1:0] to_right;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign to_left[g]  = din[(g + WIDTH - 1) % WIDTH];
        assign to_right[g] = din[(g + 1) % WIDTH];
    end

    always_comb begin
        case (dir)
            DIR_LEFT:  dout = to_left;
            DIR_RIGHT: dout = to_right;
            default:   dout = din;
        endcase
    end
endmodule

// File: rtl/grid_seq.sv
module grid_seq
    import grid_pkg::*;
#(
    parameter int ROWS = 16,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_shift,
    input  logic          move_left,
    input  logic          move_right,
    input  logic          start_fall,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] seq_addr,
    output logic          seq_we,
    output wsrc_t         seq_wsrc,
    output rot_dir_t      seq_dir
);
    localparam logic [AW-1:0] LAST_ROW  = AW'(ROWS - 1);
    localparam logic [AW-1:0] FALL_FROM = AW'(ROWS - 2);

    typedef struct packed {
        walk_state_t   state;
        walk_op_t      op;
        rot_dir_t      dir;
        logic [AW-1:0] row;
        logic          done;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        seq_addr = q.row;
        seq_we   = 1'b0;
        seq_wsrc = WS_ROT;
        case (q.state)
            S_IDLE: begin
                if (start_shift) begin
                    d.state = S_READ;
                    d.op    = OP_ROT;
                    d.row   = '0;
                    if (move_left && !move_right) begin
                        d.dir = DIR_LEFT;
                    end else if (move_right && !move_left) begin
                        d.dir = DIR_RIGHT;
                    end else begin
                        d.dir = DIR_HOLD;
                    end
                end else if (start_fall) begin
                    d.state = S_READ;
                    d.op    = OP_FALL;
                    d.row   = FALL_FROM;
                end
            end
            S_READ: begin
                d.state = S_WRITE;
            end
            S_WRITE: begin
                seq_we = 1'b1;
                if (q.op == OP_ROT) begin
                    seq_wsrc = WS_ROT;
                    if (q.row == LAST_ROW) begin
                        d.state = S_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.row   = q.row + AW'(1);
                        d.state = S_READ;
                    end
                end else begin
                    seq_wsrc = WS_COPY;
                    seq_addr = q.row + AW'(1);
                    if (q.row == '0) begin
                        d.state = S_CLEAR;
                    end else begin
                        d.row   = q.row - AW'(1);
                        d.state = S_READ;
                    end
                end
            end
            S_CLEAR: begin
                seq_we   = 1'b1;
                seq_wsrc = WS_ZERO;
                seq_addr = '0;
                d.state  = S_IDLE;
                d.done   = 1'b1;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, op: OP_ROT, dir: DIR_HOLD, row: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.state != S_IDLE);
    assign done    = q.done;
    assign seq_dir = q.dir;
endmodule

// File: rtl/grid_engine.sv
module grid_engine
    import grid_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_shift,
    input  logic             move_left,
    input  logic             move_right,
    input  logic             start_fall,
    input  logic [AW-1:0]    host_addr,
    input  logic             host_we,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy,
    output logic             done
);
    logic [AW-1:0]    seq_addr;
    logic             seq_we;
    wsrc_t            seq_wsrc;
    rot_dir_t         seq_dir;
    logic [AW-1:0]    ram_addr;
    logic             ram_we;
    logic [WIDTH-1:0] ram_wdata;
    logic [WIDTH-1:0] ram_rdata;
    logic [WIDTH-1:0] rotated;

    grid_seq #(.ROWS(ROWS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_shift (start_shift),
        .move_left   (move_left),
        .move_right  (move_right),
        .start_fall  (start_fall),
        .busy        (busy),
        .done        (done),
        .seq_addr    (seq_addr),
        .seq_we      (seq_we),
        .seq_wsrc    (seq_wsrc),
        .seq_dir     (seq_dir)
    );

    row_rotate #(.WIDTH(WIDTH)) u_rot (
        .din  (ram_rdata),
        .dir  (seq_dir),
        .dout (rotated)
    );

    always_comb begin
        if (busy) begin
            ram_addr = seq_addr;
            ram_we   = seq_we;
            case (seq_wsrc)
                WS_ROT:  ram_wdata = rotated;
                WS_COPY: ram_wdata = ram_rdata;
                default: ram_wdata = '0;
            endcase
        end else begin
            ram_addr  = host_addr;
            ram_we    = host_we;
            ram_wdata = host_wdata;
        end
    end

    grid_ram #(.ROWS(ROWS), .WIDTH(WIDTH)) u_ram (
        .clk     (clk),
        .addr    (ram_addr),
        .we      (ram_we),
        .wdata   (ram_wdata),
        .rdata_q (ram_rdata)
    );

    assign rd_data = ram_rdata;
endmodule

// File: rtl/grid_engine_chk.sv
module grid_engine_chk #(
    parameter int ROWS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start_shift,
    input logic start_fall,
    input logic busy,
    input logic done
);
    localparam int MAXB = 2 * ROWS;
    localparam int CW   = $clog2(MAXB + 2);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + CW'(1);
        end else begin
            busy_cnt <= '0;
        end
    end

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (start_shift || start_fall)) |=> busy);

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CW'(MAXB)));

    p_done_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |=> !done);
endmodule

bind grid_engine grid_engine_chk #(.ROWS(ROWS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_shift (start_shift),
    .start_fall  (start_fall),
    .busy        (busy),
    .done        (done)
);

// File: tb/grid_engine_bench.sv
module grid_engine_bench;
    localparam int ROWS  = 16;
    localparam int WIDTH = 8;
    localparam int AW    = $clog2(ROWS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_shift = 1'b0;
    logic             move_left = 1'b0;
    logic             move_right = 1'b0;
    logic             start_fall = 1'b0;
    logic [AW-1:0]    host_addr = '0;
    logic             host_we = 1'b0;
    logic [WIDTH-1:0] host_wdata = '0;
    logic [WIDTH-1:0] rd_data;
    logic             busy;
    logic             done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [WIDTH-1:0] model [ROWS];

    always #5 clk = ~clk;

    grid_engine #(.ROWS(ROWS), .WIDTH(WIDTH)) u_grid_engine (
        .clk(clk), .rst_n(rst_n), .start_shift(start_shift),
        .move_left(move_left), .move_right(move_right), .start_fall(start_fall),
        .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [WIDTH-1:0] v);
        @(negedge clk);
        host_addr = AW'(a); host_wdata = v; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [WIDTH-1:0] v);
        @(negedge clk);
        host_addr = AW'(a);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic load_grid(input int seed);
        for (int i = 0; i < ROWS; i++) begin
            model[i] = WIDTH'(i * 37 + seed * 11 + 3);
            host_write(i, model[i]);
        end
    endtask

    task automatic compare_grid(input string req);
        logic [WIDTH-1:0] v;
        for (int i = 0; i < ROWS; i++) begin
            host_read(i, v);
            check(req, int'(v), int'(model[i]));
        end
    endtask

    // Pulse a start, optionally disturb mid-walk, then measure busy and done.
    task automatic run_op(input string req, input bit ss, input bit l, input bit r,
                          input bit sf, input bit disturb, input int exp_busy);
        int n = 0;
        @(negedge clk);
        start_shift = ss; move_left = l; move_right = r; start_fall = sf;
        @(negedge clk);
        start_shift = 1'b0; start_fall = 1'b0;
        while (busy && n < 100) begin
            n++;
            if (disturb && n == 6) begin
                start_fall = 1'b1; start_shift = 1'b1; move_left = 1'b1; move_right = 1'b0;
                host_we = 1'b1; host_addr = AW'(0); host_wdata = 8'hA5;
            end else begin
                start_fall = 1'b0; start_shift = 1'b0; host_we = 1'b0;
            end
            @(negedge clk);
        end
        start_fall = 1'b0; start_shift = 1'b0; host_we = 1'b0;
        check({req, " busy length (R6)"}, n, exp_busy);
        check({req, " done pulse (R6)"}, int'(done), 1);
        @(negedge clk);
        check({req, " done ends (R6)"}, int'(done), 0);
        check({req, " idle after done (R8)"}, int'(busy), 0);
    endtask

    function automatic logic [WIDTH-1:0] rot_l(input logic [WIDTH-1:0] x);
        return (x << 1) | (x >> (WIDTH - 1));
    endfunction

    function automatic logic [WIDTH-1:0] rot_r(input logic [WIDTH-1:0] x);
        return (x >> 1) | (x << (WIDTH - 1));
    endfunction

    task automatic t_reset;
        check("R9 busy after reset", int'(busy), 0);
        check("R9 done after reset", int'(done), 0);
    endtask

    task automatic t_host;
        load_grid(1);
        compare_grid("R1 host write/read");
    endtask

    task automatic t_left;
        load_grid(2);
        run_op("R2 left", 1, 1, 0, 0, 0, 2 * ROWS);
        for (int i = 0; i < ROWS; i++) model[i] = rot_l(model[i]);
        compare_grid("R2 rotate left");
    endtask

    task automatic t_right;
        load_grid(3);
        run_op("R3 right", 1, 0, 1, 0, 0, 2 * ROWS);
        for (int i = 0; i < ROWS; i++) model[i] = rot_r(model[i]);
        compare_grid("R3 rotate right");
    endtask

    task automatic t_hold;
        load_grid(4);
        run_op("R4 both", 1, 1, 1, 0, 0, 2 * ROWS);
        compare_grid("R4 both unchanged");
        run_op("R4 neither", 1, 0, 0, 0, 0, 2 * ROWS);
        compare_grid("R4 neither unchanged");
    endtask

    task automatic t_fall;
        load_grid(5);
        run_op("R5 fall", 0, 0, 0, 1, 0, 2 * ROWS - 1);
        for (int i = ROWS - 1; i >= 1; i--) model[i] = model[i - 1];
        model[0] = '0;
        compare_grid("R5 gravity");
    endtask

    task automatic t_ignore;
        load_grid(6);
        run_op("R7 right disturbed", 1, 0, 1, 0, 1, 2 * ROWS);
        for (int i = 0; i < ROWS; i++) model[i] = rot_r(model[i]);
        compare_grid("R7 ignored during rotate");
        load_grid(7);
        run_op("R7 fall disturbed", 0, 0, 0, 1, 1, 2 * ROWS - 1);
        for (int i = ROWS - 1; i >= 1; i--) model[i] = model[i - 1];
        model[0] = '0;
        compare_grid("R7 ignored during gravity");
    endtask

    task automatic t_both_starts;
        load_grid(8);
        run_op("R8 both starts", 1, 1, 0, 1, 0, 2 * ROWS);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 no gravity follows", int'(busy), 0);
        end
        for (int i = 0; i < ROWS; i++) model[i] = rot_l(model[i]);
        compare_grid("R8 only rotation applied");
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_host();
        t_left();
        t_right();
        t_hold();
        t_fall();
        t_ignore();
        t_both_starts();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule